// File: doc/BRIEF.md
# Debounced Input-Port Interrupt Controller

This block watches an 8-bit input port and raises one interrupt request when a pin's cleaned-up level moves away from a per-pin reference value. The port is split into two groups of four pins. Each group has its own glitch filter, whose check time is picked by a 3-bit code. The filter is timed by one of two single-cycle clock-enable strobes: a fast one for microsecond windows and a slow one for millisecond windows. One code bypasses the filter altogether.

Each pin has three bits: a comparison bit, a sticky flag and an enable bit. The flag is set when the pin's filtered level goes from equal to its comparison bit to different from it. The request output is the OR of all flags that are enabled. Software uses a small register port to set comparison bits, enables and check times, to read the filtered levels, and to clear flags by writing ones.

Top module: `kport_irq`

## Requirements
- R1: After synchronous reset, every readable register (addresses 0 to 4) reads zero and `irq` is low.
- R2: The check-time register (address 3) holds the code for pins 0-3 in bits [2:0] and the code for pins 4-7 in bits [6:4]. The codes are: 111 = 4 fast strobes, 110 = 2 fast, 101 = 1 fast, 100 = 4096 slow, 011 = 2048 slow, 010 = 512 slow, 001 = 128 slow, 000 = no filter. Other bits read as zero. Any write to this register restarts both groups' period counters.
- R3: With a nonzero code of period N strobes, and the selected strobe present every cycle, a pin pulse of N cycles does not change the filtered level and sets no flag.
- R4: Under the same conditions, a pulse of 2N cycles reaches the filtered level and sets the pin's flag when its comparison bit is 0.
- R5: With code 000, a single-cycle pin pulse reaches the filtered level and sets the flag.
- R6: The two groups filter independently. A code in one group's field has no effect on the other group's pins.
- R7: A flag bit is set when its pin's filtered level changes from equal to its comparison bit to unequal. The change can come from the pin or from a write to the comparison register (address 0). A level that becomes equal sets nothing.
- R8: Flags (address 2) are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly when some pin has both its flag and its enable bit (address 1) set.
- R10: Address 4 reads the filtered levels. Addresses 0 and 1 read back the last value written.
- R11: Filter period counters advance only on the strobe that the code selects. Codes 101-111 ignore the slow strobe, and codes 001-100 ignore the fast strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Raw asynchronous input pins |
| fast_stb | input | 1 | Fast clock-enable strobe, one cycle wide |
| slow_stb | input | 1 | Slow clock-enable strobe, one cycle wide |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a check-time code changes only through a register write, which restarts the counters in the same cycle. They also assume that strobes are plain single-cycle enables in the system clock domain. The stimulus keeps to these assumptions: it writes each code before pulsing a pin, holds the pins quiet for several periods between cases, and drives each strobe either high every cycle or held low. The pulse widths are then exact multiples of the tick spacing, so the reject and accept results do not depend on the tick phase.

// File: rtl/kpi_pkg.sv
package kpi_pkg;

    localparam int CNT_W        = 12;
    localparam int RA_W         = 3;
    localparam int CT_W         = 3;
    localparam int FIELD_STRIDE = 4;

    typedef enum logic [CT_W-1:0] {
        CT_NONE    = 3'b000,
        CT_SLOW128 = 3'b001,
        CT_SLOW512 = 3'b010,
        CT_SLOW2K  = 3'b011,
        CT_SLOW4K  = 3'b100,
        CT_FAST1   = 3'b101,
        CT_FAST2   = 3'b110,
        CT_FAST4   = 3'b111
    } ct_sel_e;

    typedef enum logic [RA_W-1:0] {
        RA_CMP   = 3'd0,
        RA_EN    = 3'd1,
        RA_FLAG  = 3'd2,
        RA_CTIME = 3'd3,
        RA_LEVEL = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic             fast;
        logic             bypass;
        logic [CNT_W-1:0] last;
    } ct_cfg_t;

    function automatic ct_cfg_t decode_ct(ct_sel_e s);
        ct_cfg_t c;
        c = '{fast: 1'b0, bypass: 1'b0, last: '0};
        case (s)
            CT_FAST4:   begin c.fast = 1'b1; c.last = CNT_W'(3);    end
            CT_FAST2:   begin c.fast = 1'b1; c.last = CNT_W'(1);    end
            CT_FAST1:   begin c.fast = 1'b1; c.last = CNT_W'(0);    end
            CT_SLOW4K:  c.last = CNT_W'(4095);
            CT_SLOW2K:  c.last = CNT_W'(2047);
            CT_SLOW512: c.last = CNT_W'(511);
            CT_SLOW128: c.last = CNT_W'(127);
            default:    c.bypass = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/kpi_sync.sv
module kpi_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/kpi_tick.sv
module kpi_tick
    import kpi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ct_sel_e sel_i,
    input  logic    restart_i,
    input  logic    fast_stb_i,
    input  logic    slow_stb_i,
    output logic    tick_o,
    output logic    bypass_o
);
    ct_cfg_t          cfg;
    logic             stb;
    logic [CNT_W-1:0] cnt_q;

    assign cfg      = decode_ct(sel_i);
    assign stb      = cfg.fast ? fast_stb_i : slow_stb_i;
    assign bypass_o = cfg.bypass;
    assign tick_o   = !cfg.bypass && stb && (cnt_q == cfg.last);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (!cfg.bypass && stb) begin
            cnt_q <= (cnt_q == cfg.last) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= cfg.last)); // R2

    AST_IDLE_NO_ADV: assert property (@(posedge clk) disable iff (rst)
        (!restart_i && !stb) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/kpi_filter.sv
module kpi_filter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         bypass_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] level_o
);
    logic [W-1:0] samp_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] agree;

    assign agree = ~(din_i ^ samp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
            lvl_q  <= '0;
        end else if (bypass_i) begin
            samp_q <= din_i;
            lvl_q  <= din_i;
        end else if (tick_i) begin
            samp_q <= din_i;
            lvl_q  <= (agree & din_i) | (~agree & lvl_q);
        end
    end

    assign level_o = lvl_q;

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bypass_i && !tick_i) |=> $stable(level_o)); // R3
endmodule

// File: rtl/kport_irq.sv
module kport_irq
    import kpi_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int GRP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pins_i,
    input  logic              fast_stb,
    input  logic              slow_stb,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NGRP = PORT_W / GRP_W;

    ct_sel_e           sel_q [NGRP];
    logic [PORT_W-1:0] cmp_q;
    logic [PORT_W-1:0] en_q;
    logic [PORT_W-1:0] flag_q;
    logic [PORT_W-1:0] mis_q;
    logic [PORT_W-1:0] pins_s;
    logic [PORT_W-1:0] level;
    logic [PORT_W-1:0] mismatch;
    logic [PORT_W-1:0] set_vec;
    logic [PORT_W-1:0] clr_vec;
    logic [NGRP-1:0]   tick;
    logic [NGRP-1:0]   byp;
    logic              ct_wr;

    assign ct_wr = reg_wr && (reg_addr == RA_CTIME);

    kpi_sync #(.W(PORT_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_i),
        .q_o (pins_s)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        kpi_tick u_tick (
            .clk        (clk),
            .rst        (rst),
            .sel_i      (sel_q[g]),
            .restart_i  (ct_wr),
            .fast_stb_i (fast_stb),
            .slow_stb_i (slow_stb),
            .tick_o     (tick[g]),
            .bypass_o   (byp[g])
        );

        kpi_filter #(.W(GRP_W)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (tick[g]),
            .bypass_i (byp[g]),
            .din_i    (pins_s[g*GRP_W +: GRP_W]),
            .level_o  (level[g*GRP_W +: GRP_W])
        );
    end

    assign mismatch = level ^ cmp_q;
    assign set_vec  = mismatch & ~mis_q;
    assign clr_vec  = (reg_wr && (reg_addr == RA_FLAG)) ? reg_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            en_q   <= '0;
            flag_q <= '0;
            mis_q  <= '0;
            for (int g = 0; g < NGRP; g++) sel_q[g] <= CT_NONE;
        end else begin
            mis_q  <= mismatch;
            flag_q <= (flag_q & ~clr_vec) | set_vec;
            if (reg_wr && (reg_addr == RA_CMP)) cmp_q <= reg_wdata;
            if (reg_wr && (reg_addr == RA_EN))  en_q  <= reg_wdata;
            if (ct_wr) begin
                for (int g = 0; g < NGRP; g++)
                    sel_q[g] <= ct_sel_e'(reg_wdata[g*FIELD_STRIDE +: CT_W]);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CMP:   reg_rdata = cmp_q;
            RA_EN:    reg_rdata = en_q;
            RA_FLAG:  reg_rdata = flag_q;
            RA_LEVEL: reg_rdata = level;
            RA_CTIME: begin
                for (int g = 0; g < NGRP; g++)
                    reg_rdata[g*FIELD_STRIDE +: CT_W] = sel_q[g];
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(flag_q & en_q);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec))); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((~flag_q & $past(flag_q) & ~$past(clr_vec)) == '0)); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_q != '0)); // R9
endmodule

// File: tb/kport_irq_test.sv
`timescale 1ns/1ps
module kport_irq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pins = '0;
    logic       fast_en = 1'b1;
    logic       slow_en = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    int         nchk = 0;
    int         nfail = 0;

    always #2.5 clk = ~clk;

    kport_irq uut (
        .clk       (clk),
        .rst       (rst),
        .pins_i    (pins),
        .fast_stb  (fast_en),
        .slow_stb  (slow_en),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    function automatic int period_of(int s);
        case (s)
            1: return 128;
            2: return 512;
            3: return 2048;
            4: return 4096;
            5: return 1;
            6: return 2;
            7: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(int p, int w);
        @(negedge clk);
        pins[p] = 1'b1;
        repeat (w) @(negedge clk);
        pins[p] = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_sel(int g, int s);
        logic [7:0] v;
        int n;
        int p;
        n = period_of(s);
        p = g * 4 + (s % 4);
        wr(3'd3, 8'(s << (4 * g)));
        wr(3'd2, 8'hFF);
        idle(4);
        if (n > 0) begin
            pulse(p, n);
            idle(3 * n + 8);
            rd(3'd2, v);
            check($sformatf("R2 R3 grp%0d sel%0d reject flag", g, s), 8'(v[p]), 8'd0);
            rd(3'd4, v);
            check($sformatf("R3 grp%0d sel%0d reject level", g, s), v, 8'd0);
            pulse(p, 2 * n);
            idle(3 * n + 8);
            rd(3'd2, v);
            check($sformatf("R2 R4 grp%0d sel%0d accept flag", g, s), 8'(v[p]), 8'd1);
        end else begin
            pulse(p, 1);
            idle(8);
            rd(3'd2, v);
            check($sformatf("R5 grp%0d bypass flag", g), 8'(v[p]), 8'd1);
        end
        rd(3'd4, v);
        check($sformatf("R4 grp%0d sel%0d level settles", g, s), v, 8'd0);
        wr(3'd2, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(4);
        rst = 1'b0;
        idle(2);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 addr%0d", a), v, 8'd0);
        end
        check("R1 irq", 8'(irq), 8'd0);

        // R2 R3 R4 R5 sweep over codes
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 8; s++) begin
                if (g == 1 && !(s == 0 || s == 1 || s == 5 || s == 6)) continue;
                run_sel(g, s);
            end
        end

        // R6: group 0 slow filter, group 1 bypass
        wr(3'd3, 8'h04);
        wr(3'd2, 8'hFF);
        idle(4);
        pulse(0, 1);
        pulse(4, 1);
        idle(10);
        rd(3'd2, v);
        check("R6 independent groups", v, 8'h10);
        wr(3'd2, 8'hFF);

        // R11: fast code ignores slow strobe
        wr(3'd3, 8'h07);
        fast_en = 1'b0;
        idle(4);
        pulse(0, 20);
        idle(10);
        rd(3'd4, v);
        check("R11 fast code without fast strobe level", v, 8'd0);
        rd(3'd2, v);
        check("R11 fast code without fast strobe flag", v, 8'd0);
        fast_en = 1'b1;
        // R11: slow code ignores fast strobe
        wr(3'd3, 8'h01);
        slow_en = 1'b0;
        idle(4);
        pulse(1, 300);
        idle(10);
        rd(3'd4, v);
        check("R11 slow code without slow strobe level", v, 8'd0);
        slow_en = 1'b1;
        wr(3'd2, 8'hFF);

        // R7 R8 R9 in bypass
        wr(3'd3, 8'h00);
        idle(4);
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'h04);
        idle(2);
        rd(3'd2, v);
        check("R7 cmp write mismatch sets flag", v, 8'h04);
        check("R9 flag without enable", 8'(irq), 8'd0);
        wr(3'd1, 8'h04);
        idle(1);
        check("R9 flag with enable", 8'(irq), 8'd1);
        wr(3'd1, 8'h02);
        idle(1);
        check("R9 enable on other pin", 8'(irq), 8'd0);
        wr(3'd2, 8'h04);
        rd(3'd2, v);
        check("R8 write one clears", v, 8'h00);
        wr(3'd0, 8'h0C);
        idle(2);
        wr(3'd2, 8'h00);
        rd(3'd2, v);
        check("R8 write zero no effect", v, 8'h08);
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'h2C);
        wr(3'd2, 8'h20);
        rd(3'd2, v);
        check("R8 set beats clear", v, 8'h20);
        wr(3'd2, 8'hFF);
        rd(3'd2, v);
        check("R8 clear after set", v, 8'h00);

        // R7: pin path
        wr(3'd0, 8'h40);
        idle(2);
        wr(3'd2, 8'hFF);
        @(negedge clk) pins[6] = 1'b1;
        idle(8);
        rd(3'd2, v);
        check("R7 level becomes equal sets nothing", v, 8'h00);
        rd(3'd4, v);
        check("R10 level readback", v, 8'h40);
        @(negedge clk) pins[6] = 1'b0;
        idle(8);
        rd(3'd2, v);
        check("R7 level becomes unequal sets flag", v, 8'h40);

        // R10 R2 readback
        wr(3'd0, 8'hA5);
        rd(3'd0, v);
        check("R10 cmp readback", v, 8'hA5);
        wr(3'd1, 8'h3C);
        rd(3'd1, v);
        check("R10 enable readback", v, 8'h3C);
        wr(3'd3, 8'hFF);
        rd(3'd3, v);
        check("R2 ctime readback masks spare bits", v, 8'h77);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule